// File: doc/BRIEF.md
# Peripheral Event Routing Fabric

This block carries event signals from peripherals to the consumers that listen for them, across six independent channels. Each channel picks one wire out of a wide array of peripheral event signals. The array is arranged as sources, and each source has eight signals. Before the result leaves on a per-channel output, the channel can turn edges into single-cycle pulses, invert the result with a software-held level, and add a software-requested pulse.

A word-addressed register port configures the block. A write strobe moves a byte address and a data word into the block, and the read data follows the address combinationally. A trace trigger selector lets any one channel start a trace unit and any one channel stop it. A routing register holds pin enables and a location code, and the block drives these out to the pin multiplexer.

Top module: `evr_fabric`

## Requirements
- R1: After reset every register reads 0, every channel output is 0, both trace triggers are 0, and the pin enable and location outputs are 0.
- R2: A channel control word sits at byte address 0x10+4·n and holds signal select in bits 2:0, source select in bits 21:16, edge mode in bits 25:24 and the bypass flag in bit 28. With edge mode 0, the channel output equals srcSig[source·8+signal] in the same cycle.
- R3: A source select of 0 forces the channel's selected signal low, whatever srcSig carries.
- R4: With edge mode 1, the output is high for exactly the one cycle in which the selected signal is 1 and its value at the previous clock edge was 0.
- R5: With edge mode 2, the output is high for exactly the one cycle in which the selected signal is 0 and its value at the previous clock edge was 1.
- R6: With edge mode 3, the output is high for one cycle whenever the selected signal differs from its value at the previous clock edge.
- R7: When bit 28 is set, the edge stage is bypassed, the raw selected signal is used, and the edge mode has no effect.
- R8: The level register at address 0x4 holds one bit per channel in bits 5:0, and the processed signal is XORed with that bit.
- R9: Writing the pulse register at address 0x0 with bit n set drives channel n high for exactly the cycle after the write. This register always reads 0.
- R10: In the first cycle after a write to a channel's control word, that channel's edge stage emits no pulse, even when the new selection differs from the value stored at the previous edge.
- R11: The trace register sits at 0x40. Bit 0 enables start and bits 3:1 pick the channel that drives traceStart. Bit 8 enables stop and bits 11:9 pick the channel that drives traceStop. A disabled trigger or a channel number of 6 or 7 gives 0.
- R12: The routing register sits at 0x8. Bits 3:0 drive pinEn and bits 10:8 drive pinLoc. All registers read back only their defined bits: control mask 0x133F0007, trace mask 0xF0F, routing mask 0x70F, level mask 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| srcSig | input | 512 | Peripheral event signals, index source·8+signal |
| chOut | output | 6 | Per-channel routed event |
| traceStart | output | 1 | Trace start trigger |
| traceStop | output | 1 | Trace stop trigger |
| pinEn | output | 4 | Pin enables for channels 0 to 3 |
| pinLoc | output | 3 | Pin location code |

## Verification
The bench checks a reconfiguration where the old source was low and the new one is high while edge mode is rising. A design that compares against the stale stored value would emit a false pulse in the first cycle. Source 0 is checked with every event wire high, and a design that forgot to force it low would pass a signal through. The bench checks trace channel numbers 6 and 7, which must not alias onto real channels. It also checks that a software pulse lasts exactly one cycle and reads back as zero, and that bypass mode ignores the edge mode, since an edge detector left active there would turn a steady level into one pulse.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int CH_COUNT  = 6;
  localparam int SRC_W     = 6;
  localparam int SEL_W     = 3;
  localparam int TRC_W     = 3;
  localparam int PIN_COUNT = 4;
  localparam int LOC_W     = 3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic             bypass;
    edgeMode_e        edgeMode;
    logic [SRC_W-1:0] src;
    logic [SEL_W-1:0] sig;
  } chCfg_t;

  typedef struct packed {
    logic             startEn;
    logic [TRC_W-1:0] startSel;
    logic             stopEn;
    logic [TRC_W-1:0] stopSel;
  } trcCfg_t;

  typedef struct packed {
    logic [CH_COUNT-1:0] swPulse;
    logic [CH_COUNT-1:0] cfgNew;
  } ctrlStb_t;
endpackage

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [7:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output chCfg_t               chCfg [CH_COUNT],
  output logic [CH_COUNT-1:0]  swLevel,
  output ctrlStb_t             stb,
  output trcCfg_t              trc,
  output logic [PIN_COUNT-1:0] pinEn,
  output logic [LOC_W-1:0]     pinLoc
);
  localparam logic [7:0] ADDR_PULSE = 8'h00;
  localparam logic [7:0] ADDR_LEVEL = 8'h04;
  localparam logic [7:0] ADDR_ROUTE = 8'h08;
  localparam logic [7:0] ADDR_CH0   = 8'h10;
  localparam logic [7:0] ADDR_TRACE = 8'h40;

  function automatic logic [31:0] packCfg(chCfg_t c);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = c.sig;
    w[21:16] = c.src;
    w[25:24] = c.edgeMode;
    w[28]    = c.bypass;
    return w;
  endfunction

  function automatic logic [7:0] chAddr(int idx);
    return ADDR_CH0 + 8'(4 * idx);
  endfunction

  logic pulseWr;
  assign pulseWr = regWe && (regAddr == ADDR_PULSE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swLevel     <= '0;
      trc         <= '0;
      pinEn       <= '0;
      pinLoc      <= '0;
      stb.swPulse <= '0;
    end else begin
      stb.swPulse <= pulseWr ? regWdata[CH_COUNT-1:0] : '0;
      if (regWe) begin
        if (regAddr == ADDR_LEVEL) swLevel <= regWdata[CH_COUNT-1:0];
        if (regAddr == ADDR_ROUTE) begin
          pinEn  <= regWdata[PIN_COUNT-1:0];
          pinLoc <= regWdata[8 +: LOC_W];
        end
        if (regAddr == ADDR_TRACE) begin
          trc.startEn  <= regWdata[0];
          trc.startSel <= regWdata[1 +: TRC_W];
          trc.stopEn   <= regWdata[8];
          trc.stopSel  <= regWdata[9 +: TRC_W];
        end
      end
    end
  end

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_chReg
    logic cfgWr;
    assign cfgWr = regWe && (regAddr == chAddr(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chCfg[i]      <= '0;
        stb.cfgNew[i] <= 1'b0;
      end else begin
        stb.cfgNew[i] <= cfgWr;
        if (cfgWr) begin
          chCfg[i].sig      <= regWdata[2:0];
          chCfg[i].src      <= regWdata[21:16];
          chCfg[i].edgeMode <= edgeMode_e'(regWdata[25:24]);
          chCfg[i].bypass   <= regWdata[28];
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_LEVEL: regRdata[CH_COUNT-1:0] = swLevel;
      ADDR_ROUTE: begin
        regRdata[PIN_COUNT-1:0] = pinEn;
        regRdata[8 +: LOC_W]    = pinLoc;
      end
      ADDR_TRACE: begin
        regRdata[0]          = trc.startEn;
        regRdata[1 +: TRC_W] = trc.startSel;
        regRdata[8]          = trc.stopEn;
        regRdata[9 +: TRC_W] = trc.stopSel;
      end
      default: begin
        for (int i = 0; i < CH_COUNT; i++)
          if (regAddr == chAddr(i)) regRdata = packCfg(chCfg[i]);
      end
    endcase
  end

  // R9: a software pulse strobe exists only after a pulse-register write
  p_stb_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.swPulse != '0) |-> $past(regWe && regAddr == ADDR_PULSE));

  // R10: the reconfiguration marker follows a write to a control word
  p_cfgnew_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cfgNew != '0) |-> $past(regWe && regAddr >= ADDR_CH0 &&
                                 regAddr < ADDR_CH0 + 8'(4 * CH_COUNT)));
endmodule

// File: rtl/evr_datapath.sv
module evr_datapath
  import evr_pkg::*;
#(
  parameter int SIG_SPAN = 1 << (SRC_W + SEL_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SIG_SPAN-1:0] srcSig,
  input  chCfg_t              chCfg [CH_COUNT],
  input  logic [CH_COUNT-1:0] swLevel,
  input  ctrlStb_t            stb,
  input  trcCfg_t             trc,
  output logic [CH_COUNT-1:0] chOut,
  output logic                traceStart,
  output logic                traceStop
);
  localparam int IDX_W    = SRC_W + SEL_W;
  localparam int TRC_SPAN = 1 << TRC_W;

  logic [CH_COUNT-1:0] selSig;
  logic [CH_COUNT-1:0] prevSel;

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
    logic [IDX_W-1:0] idx;
    logic             edgeOut;

    assign idx       = {chCfg[i].src, chCfg[i].sig};
    assign selSig[i] = (chCfg[i].src != '0) && srcSig[idx];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevSel[i] <= 1'b0;
      else       prevSel[i] <= selSig[i];
    end

    always_comb begin
      if (chCfg[i].bypass || chCfg[i].edgeMode == EDGE_OFF) begin
        edgeOut = selSig[i];
      end else if (stb.cfgNew[i]) begin
        edgeOut = 1'b0;
      end else begin
        unique case (chCfg[i].edgeMode)
          EDGE_RISE: edgeOut = selSig[i] && !prevSel[i];
          EDGE_FALL: edgeOut = !selSig[i] && prevSel[i];
          default:   edgeOut = selSig[i] ^ prevSel[i];
        endcase
      end
    end

    assign chOut[i] = (edgeOut ^ swLevel[i]) | stb.swPulse[i];

    // R4: a rising-mode pulse needs a real rising edge on the selection
    p_rise_real_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !chCfg[i].bypass && chCfg[i].edgeMode == EDGE_RISE &&
       !stb.cfgNew[i] && !swLevel[i] && !stb.swPulse[i] && chOut[i])
      |-> (selSig[i] && !$past(selSig[i])));
  end

  logic [TRC_SPAN-1:0] chPad;
  assign chPad      = {{(TRC_SPAN - CH_COUNT){1'b0}}, chOut};
  assign traceStart = trc.startEn && chPad[trc.startSel];
  assign traceStop  = trc.stopEn && chPad[trc.stopSel];

  // R11: a trigger needs its enable and a valid channel number
  p_start_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    traceStart |-> (trc.startEn && trc.startSel < TRC_W'(CH_COUNT)));
  p_stop_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    traceStop |-> (trc.stopEn && trc.stopSel < TRC_W'(CH_COUNT)));
endmodule

// File: rtl/evr_fabric.sv
module evr_fabric
  import evr_pkg::*;
#(
  parameter int SIG_SPAN = 1 << (SRC_W + SEL_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [7:0]           regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [SIG_SPAN-1:0]  srcSig,
  output logic [CH_COUNT-1:0]  chOut,
  output logic                 traceStart,
  output logic                 traceStop,
  output logic [PIN_COUNT-1:0] pinEn,
  output logic [LOC_W-1:0]     pinLoc
);
  chCfg_t              chCfg [CH_COUNT];
  logic [CH_COUNT-1:0] swLevel;
  ctrlStb_t            stb;
  trcCfg_t             trc;

  evr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .chCfg(chCfg),
    .swLevel(swLevel), .stb(stb), .trc(trc), .pinEn(pinEn), .pinLoc(pinLoc)
  );

  evr_datapath #(.SIG_SPAN(SIG_SPAN)) u_dp (
    .clk(clk), .rstN(rstN), .srcSig(srcSig), .chCfg(chCfg),
    .swLevel(swLevel), .stb(stb), .trc(trc), .chOut(chOut),
    .traceStart(traceStart), .traceStop(traceStop)
  );
endmodule

// File: tb/tb_evr_fabric.sv
module tb_evr_fabric;
  localparam int NCH = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [511:0] srcSig = '0;
  logic [5:0]   chOut;
  logic         traceStart, traceStop;
  logic [3:0]   pinEn;
  logic [2:0]   pinLoc;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  evr_fabric dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcSig(srcSig),
    .chOut(chOut), .traceStart(traceStart), .traceStop(traceStop),
    .pinEn(pinEn), .pinLoc(pinLoc)
  );

  // Reference state, built from the requirements
  logic [31:0] mCtrl [NCH];
  logic [5:0]  mLvl, mStb, mNew, mPrev;
  logic [31:0] mTrc, mRoute;

  function automatic logic expSel(int c);
    int src = int'(mCtrl[c][21:16]);
    int sig = int'(mCtrl[c][2:0]);
    if (src == 0) return 1'b0;
    return srcSig[src * 8 + sig];
  endfunction

  function automatic logic expOut(int c);
    logic s = expSel(c);
    logic e;
    logic [1:0] m = mCtrl[c][25:24];
    if (mCtrl[c][28] || m == 2'd0) e = s;
    else if (mNew[c]) e = 1'b0;
    else if (m == 2'd1) e = s & ~mPrev[c];
    else if (m == 2'd2) e = ~s & mPrev[c];
    else e = s ^ mPrev[c];
    return (e ^ mLvl[c]) | mStb[c];
  endfunction

  function automatic logic expTrig(logic en, logic [2:0] sel);
    if (!en || sel > 3'd5) return 1'b0;
    return expOut(int'(sel));
  endfunction

  function automatic string tagFor(int c);
    if (mCtrl[c][28]) return "R7";
    if (mCtrl[c][21:16] == 6'd0) return "R3";
    case (mCtrl[c][25:24])
      2'd1:    return "R4";
      2'd2:    return "R5";
      2'd3:    return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) mCtrl[c] <= '0;
      mLvl <= '0; mStb <= '0; mNew <= '0; mPrev <= '0; mTrc <= '0; mRoute <= '0;
    end else begin
      logic [5:0] nNew;
      logic [5:0] nPrev;
      nNew = '0;
      for (int c = 0; c < NCH; c++) nPrev[c] = expSel(c);
      mPrev <= nPrev;
      mStb  <= (regWe && regAddr == 8'h00) ? regWdata[5:0] : 6'd0;
      if (regWe) begin
        if (regAddr == 8'h04) mLvl <= regWdata[5:0];
        if (regAddr == 8'h08) mRoute <= regWdata & 32'h70F;
        if (regAddr == 8'h40) mTrc <= regWdata & 32'hF0F;
        for (int c = 0; c < NCH; c++)
          if (regAddr == 8'(8'h10 + 4 * c)) begin
            mCtrl[c] <= regWdata & 32'h133F0007;
            nNew[c] = 1'b1;
          end
      end
      mNew <= nNew;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdCheck(string tag, logic [7:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdata, exp);
  endtask

  task automatic checkAll();
    #2;
    for (int c = 0; c < NCH; c++) check(tagFor(c), {31'd0, chOut[c]}, {31'd0, expOut(c)});
    check("R11", {31'd0, traceStart}, {31'd0, expTrig(mTrc[0], mTrc[3:1])});
    check("R11", {31'd0, traceStop},  {31'd0, expTrig(mTrc[8], mTrc[11:9])});
    check("R12", {25'd0, pinLoc, pinEn}, {25'd0, mRoute[10:8], mRoute[3:0]});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    srcSig = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: reset state
    check("R1", {26'd0, chOut}, 32'd0);
    check("R1", {30'd0, traceStart, traceStop}, 32'd0);
    check("R1", {25'd0, pinLoc, pinEn}, 32'd0);
    rdCheck("R1", 8'h04, 32'd0);
    rdCheck("R1", 8'h08, 32'd0);
    rdCheck("R1", 8'h40, 32'd0);
    for (int c = 0; c < NCH; c++) rdCheck("R1", 8'(8'h10 + 4 * c), 32'd0);

    // R2: pass-through of source 5 signal 3 on channel 1
    srcSig = '0;
    wr(8'h14, (32'd5 << 16) | 32'd3);
    #2 check("R2", {31'd0, chOut[1]}, 32'd0);
    srcSig[43] = 1'b1;
    #2 check("R2", {31'd0, chOut[1]}, 32'd1);

    // R3: source 0 stays low with every wire high
    wr(8'h18, 32'd5);
    srcSig = '1;
    #2 check("R3", {31'd0, chOut[2]}, 32'd0);

    // R4: rising edge on channel 3 (source 1 signal 0 = bit 8)
    srcSig = '0;
    wr(8'h1C, 32'h0101_0000);
    @(negedge clk); srcSig[8] = 1'b1;
    #2 check("R4", {31'd0, chOut[3]}, 32'd1);
    @(negedge clk); #2 check("R4", {31'd0, chOut[3]}, 32'd0);

    // R5: falling edge on channel 4, same wire
    wr(8'h20, 32'h0201_0000);
    @(negedge clk); #2 check("R5", {31'd0, chOut[4]}, 32'd0);
    @(negedge clk); srcSig[8] = 1'b0;
    #2 check("R5", {31'd0, chOut[4]}, 32'd1);
    @(negedge clk); #2 check("R5", {31'd0, chOut[4]}, 32'd0);

    // R6: both edges on channel 5
    wr(8'h24, 32'h0301_0000);
    @(negedge clk); srcSig[8] = 1'b1;
    #2 check("R6", {31'd0, chOut[5]}, 32'd1);
    @(negedge clk); srcSig[8] = 1'b0;
    #2 check("R6", {31'd0, chOut[5]}, 32'd1);
    @(negedge clk); #2 check("R6", {31'd0, chOut[5]}, 32'd0);

    // R7: bypass with rising mode holds a steady level
    srcSig[8] = 1'b1;
    wr(8'h1C, 32'h1101_0000);
    @(negedge clk); #2 check("R7", {31'd0, chOut[3]}, 32'd1);
    @(negedge clk); #2 check("R7", {31'd0, chOut[3]}, 32'd1);

    // R8: level bit 3 inverts channel 3
    wr(8'h04, 32'h08);
    #2 check("R8", {31'd0, chOut[3]}, 32'd0);
    rdCheck("R8", 8'h04, 32'h08);
    wr(8'h04, 32'h00);

    // R9: software pulse on every channel for one cycle
    srcSig = '0;
    wr(8'h00, 32'h3F);
    #2 check("R9", {26'd0, chOut}, 32'h3F);
    rdCheck("R9", 8'h00, 32'd0);
    @(negedge clk); #2 check("R9", {26'd0, chOut}, 32'd0);

    // R10: channel 0 moves from a low source to a high one in rising mode
    srcSig[16] = 1'b0; srcSig[8] = 1'b1;
    wr(8'h10, 32'h0102_0000);
    @(negedge clk);
    wr(8'h10, 32'h0101_0000);
    #2 check("R10", {31'd0, chOut[0]}, 32'd0);
    @(negedge clk); #2 check("R10", {31'd0, chOut[0]}, 32'd0);

    // R11: channel 3 is high through bypass; start on ch3, stop on invalid 6
    wr(8'h1C, 32'h1101_0000);
    wr(8'h40, 32'h0000_0D07);
    #2 check("R11", {31'd0, traceStart}, 32'd1);
    check("R11", {31'd0, traceStop}, 32'd0);
    wr(8'h40, 32'h0000_0706);
    #2 check("R11", {30'd0, traceStart, traceStop}, 32'd1);

    // R12: routing outputs and readback masks
    wr(8'h08, 32'hFFFF_FFFF);
    #2 check("R12", {25'd0, pinLoc, pinEn}, 32'h7F);
    rdCheck("R12", 8'h08, 32'h70F);
    wr(8'h24, 32'hFFFF_FFFF);
    rdCheck("R12", 8'h24, 32'h133F_0007);
    wr(8'h40, 32'hFFFF_FFFF);
    rdCheck("R12", 8'h40, 32'hF0F);

    // Random phase against the reference state
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      regWe = 1'b0;
      for (int w = 0; w < 16; w++) srcSig[w * 32 +: 32] = $urandom;
      if ($urandom_range(0, 5) == 0) begin
        int pick = $urandom_range(0, 9);
        regWe    = 1'b1;
        regWdata = $urandom;
        case (pick)
          0: regAddr = 8'h00;
          1: regAddr = 8'h04;
          2: regAddr = 8'h08;
          3: regAddr = 8'h40;
          default: regAddr = 8'(8'h10 + 4 * (pick - 4));
        endcase
      end
      checkAll();
    end
    @(negedge clk);
    regWe = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule